// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked on-chip request port and an external asynchronous static RAM (8-bit words, 19-bit address by default). Each accepted request becomes one complete read or write cycle on the RAM pins. The controller drives both chip enables, the output enable and the write enable from registers, so none of these strobes glitches. Every phase length is a parameter counted in clock cycles. The integrator rounds each nanosecond limit up at the chosen clock rate.

A read holds the address and both enables, with output enable low, for the access time. It then spends one capture cycle and registers the RAM data. A one-cycle valid pulse flags the registered data. A write drives the data pins from a setup phase through a write-enable pulse and a recovery phase. Output enable stays high for the whole write, so the two sides never drive the shared pins together. A write that follows a read waits out the RAM's output-release delay before the controller drives the data pins.

Requests are taken only while the ready output is high, and it is high only when the block is idle. The data-pin driver is split into an output value, an enable and an input value, so that the pad ring forms the tri-state buffer.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, ready_o is 1, rvalid_o is 0, ram_sel_n_o is 1, ram_sel_o is 0, ram_rd_n_o is 1, ram_wr_n_o is 1 and ram_dq_en_o is 0.
- R2: A request is taken only on a clock edge where req_i and ready_o are both 1. ready_o goes low in the next cycle and stays low until the operation finishes. A request raised while ready_o is low is ignored.
- R3: A read (wr_i = 0) drives ram_sel_n_o = 0, ram_sel_o = 1, ram_rd_n_o = 0 and ram_wr_n_o = 1, with ram_addr_o = addr_i, for TRD_CYC cycles plus one capture cycle. ready_o is low for exactly TRD_CYC + 1 cycles.
- R4: rdata_o takes the value on ram_dq_i at the end of the capture cycle. rvalid_o is 1 for exactly one cycle, and that cycle is the first cycle in which ready_o is back to 1.
- R5: During every write, ram_rd_n_o stays 1. ram_dq_en_o is 1 with ram_dq_o = wdata_i from the first setup cycle to the last recovery cycle.
- R6: A write has three phases. Setup lasts TSU_CYC cycles with ram_wr_n_o = 1. The pulse phase holds ram_wr_n_o = 0 for PULSE = max(TWP_CYC, TDS_CYC - TSU_CYC) cycles. Recovery lasts REC = max(TWR_CYC, TWC_CYC - TSU_CYC - PULSE) cycles with ram_wr_n_o = 1. ready_o is low for TSU_CYC + PULSE + REC cycles.
- R7: While the RAM is selected, ram_addr_o does not change from one cycle to the next.
- R8: The first write after a read is preceded by TTURN_CYC cycles in which the RAM is deselected and ram_dq_en_o is 0. This adds TTURN_CYC cycles to that write's ready-low time. A write after a write, or the first write after reset, has no such gap.
- R9: Whenever ready_o is 1, the RAM is deselected (ram_sel_n_o = 1, ram_sel_o = 0), ram_rd_n_o is 1 and ram_dq_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when ready_o is 1 |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| ready_o | output | 1 | Idle, can take a request |
| rdata_o | output | DW | Registered read data |
| rvalid_o | output | 1 | One-cycle pulse, rdata_o valid |
| ram_addr_o | output | AW | RAM address pins |
| ram_sel_n_o | output | 1 | Active-low chip enable |
| ram_sel_o | output | 1 | Active-high chip enable |
| ram_rd_n_o | output | 1 | Active-low output enable |
| ram_wr_n_o | output | 1 | Active-low write enable |
| ram_dq_o | output | DW | Data value to drive onto the pins |
| ram_dq_en_o | output | 1 | Drive enable for the data pins |
| ram_dq_i | input | DW | Data sampled from the pins |

## Verification
The assertions take for granted that the timing parameters are all at least 1 and that each one already covers its nanosecond limit at the clock rate in use. They also rely on ram_dq_i being stable around the capture edge of a read. The stimulus drives inputs only at falling edges. It holds req_i for one cycle while ready_o is high, apart from one deliberate request raised while the block is busy. A bench RAM model presents valid data only after the enables and address have been steady for TRD_CYC sampled cycles, and presents inverted data before then. The same model keeps driving the pins for two cycles after output enable is released.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_ACCESS  = 3'd1,
        ST_RD_CAPTURE = 3'd2,
        ST_TURN       = 3'd3,
        ST_WR_SETUP   = 3'd4,
        ST_WR_PULSE   = 3'd5,
        ST_WR_RECOVER = 3'd6
    } ctl_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o
);

    logic [DW-1:0] rdata_d, rdata_q;
    logic          rvalid_d, rvalid_q;

    always_comb begin
        rdata_d  = take_i ? dq_i : rdata_q;
        rvalid_d = take_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rdata_q  <= rdata_d;
            rvalid_q <= rvalid_d;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    a_r4_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW      = 19,
    parameter int DW      = 8,
    parameter int TRD_CYC = 5,   // access time, >= 1
    parameter int TSU_CYC = 1,   // address/data setup before the pulse, >= 1
    parameter int TWP_CYC = 3,   // minimum write-enable low time
    parameter int TDS_CYC = 2,   // data valid before the write ends
    parameter int TWR_CYC = 1,   // recovery after write enable rises
    parameter int TWC_CYC = 5,   // minimum full write cycle
    parameter int TTURN_CYC = 2  // RAM output release after a read
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          ready_o,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o,
    output logic [AW-1:0] ram_addr_o,
    output logic          ram_sel_n_o,
    output logic          ram_sel_o,
    output logic          ram_rd_n_o,
    output logic          ram_wr_n_o,
    output logic [DW-1:0] ram_dq_o,
    output logic          ram_dq_en_o,
    input  logic [DW-1:0] ram_dq_i
);

    localparam int PULSE_LEN = max2(TWP_CYC, TDS_CYC - TSU_CYC);
    localparam int REC_LEN   = max2(TWR_CYC, TWC_CYC - TSU_CYC - PULSE_LEN);
    localparam int MAX_LEN   = max2(max2(TRD_CYC, TSU_CYC),
                                    max2(max2(PULSE_LEN, REC_LEN), TTURN_CYC));
    localparam int CW        = $clog2(MAX_LEN + 1);

    typedef struct packed {
        ctl_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          sel;
        logic          oe;
        logic          we;
        logic          drv;
        logic          after_rd;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic          load;
    logic [CW-1:0] len;
    logic          expired;
    logic          take;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .len_i     (len),
        .expired_o (expired)
    );

    sram_rd_capture #(.DW(DW)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .dq_i     (ram_dq_i),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

    always_comb begin
        c_d  = c_q;
        load = 1'b0;
        len  = '0;
        take = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    c_d.addr     = addr_i;
                    c_d.after_rd = 1'b0;
                    load         = 1'b1;
                    if (wr_i) begin
                        c_d.wdata = wdata_i;
                        if (c_q.after_rd) begin
                            c_d.st = ST_TURN;
                            len    = CW'(TTURN_CYC);
                        end else begin
                            c_d.st = ST_WR_SETUP;
                            len    = CW'(TSU_CYC);
                        end
                    end else begin
                        c_d.st = ST_RD_ACCESS;
                        len    = CW'(TRD_CYC);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (expired) c_d.st = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                take         = 1'b1;
                c_d.after_rd = 1'b1;
                c_d.st       = ST_IDLE;
            end
            ST_TURN: begin
                if (expired) begin
                    c_d.st = ST_WR_SETUP;
                    load   = 1'b1;
                    len    = CW'(TSU_CYC);
                end
            end
            ST_WR_SETUP: begin
                if (expired) begin
                    c_d.st = ST_WR_PULSE;
                    load   = 1'b1;
                    len    = CW'(PULSE_LEN);
                end
            end
            ST_WR_PULSE: begin
                if (expired) begin
                    c_d.st = ST_WR_RECOVER;
                    load   = 1'b1;
                    len    = CW'(REC_LEN);
                end
            end
            ST_WR_RECOVER: begin
                if (expired) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase

        // strobes are registered from the next state
        c_d.oe  = (c_d.st == ST_RD_ACCESS) || (c_d.st == ST_RD_CAPTURE);
        c_d.we  = (c_d.st == ST_WR_PULSE);
        c_d.drv = (c_d.st == ST_WR_SETUP) || (c_d.st == ST_WR_PULSE) ||
                  (c_d.st == ST_WR_RECOVER);
        c_d.sel = c_d.oe || c_d.drv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, addr: '0, wdata: '0, sel: 1'b0, oe: 1'b0,
                     we: 1'b0, drv: 1'b0, after_rd: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign ready_o     = (c_q.st == ST_IDLE);
    assign ram_addr_o  = c_q.addr;
    assign ram_sel_n_o = !c_q.sel;
    assign ram_sel_o   = c_q.sel;
    assign ram_rd_n_o  = !c_q.oe;
    assign ram_wr_n_o  = !c_q.we;
    assign ram_dq_o    = c_q.wdata;
    assign ram_dq_en_o = c_q.drv;

    // length of the current write-enable low run, for the width check
    logic [CW-1:0] we_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 we_run_q <= '0;
        else if (ram_wr_n_o)                        we_run_q <= '0;
        else if (we_run_q != {CW{1'b1}})            we_run_q <= we_run_q + CW'(1);
    end

    a_r1_reset_strobes: assert property (@(posedge clk)
        !rst_n |-> (ram_sel_n_o && !ram_sel_o && ram_rd_n_o && ram_wr_n_o && !ram_dq_en_o));

    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ready_o) |=> !ready_o);

    a_r4_rvalid_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> ready_o);

    a_r5_no_oe_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_wr_n_o |-> (ram_dq_en_o && ram_rd_n_o && !ram_sel_n_o && ram_sel_o));

    a_r5_drive_excludes_oe: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_en_o |-> ram_rd_n_o);

    a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_wr_n_o) |-> (we_run_q >= CW'(PULSE_LEN)));

    a_r7_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel_o && $past(ram_sel_o)) |-> $stable(ram_addr_o));

    a_r8_release_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dq_en_o) |-> ($past(ram_rd_n_o, 1) && $past(ram_rd_n_o, 2)));

    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (ram_sel_n_o && !ram_sel_o && ram_rd_n_o && !ram_dq_en_o));

endmodule

// File: tb/tb_sram_strobe_ctrl.sv
module tb_sram_strobe_ctrl;

    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NW = 1 << AW;
    localparam int TRD = 5, TSU = 1, TWP = 3, TDS = 2, TWR = 1, TWC = 5, TTURN = 2;
    localparam int PULSE  = (TWP > TDS - TSU) ? TWP : TDS - TSU;
    localparam int REC    = (TWR > TWC - TSU - PULSE) ? TWR : TWC - TSU - PULSE;
    localparam int RD_LAT = TRD + 1;
    localparam int WR_LAT = TSU + PULSE + REC;
    localparam int RAM_HOLD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          wr_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          ready_o, rvalid_o;
    logic [DW-1:0] rdata_o;
    logic [AW-1:0] ram_addr_o;
    logic          ram_sel_n_o, ram_sel_o, ram_rd_n_o, ram_wr_n_o, ram_dq_en_o;
    logic [DW-1:0] ram_dq_o, ram_dq_i;

    always #10 clk = ~clk;

    sram_strobe_ctrl #(
        .AW(AW), .DW(DW), .TRD_CYC(TRD), .TSU_CYC(TSU), .TWP_CYC(TWP),
        .TDS_CYC(TDS), .TWR_CYC(TWR), .TWC_CYC(TWC), .TTURN_CYC(TTURN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .ram_addr_o(ram_addr_o), .ram_sel_n_o(ram_sel_n_o), .ram_sel_o(ram_sel_o),
        .ram_rd_n_o(ram_rd_n_o), .ram_wr_n_o(ram_wr_n_o), .ram_dq_o(ram_dq_o),
        .ram_dq_en_o(ram_dq_en_o), .ram_dq_i(ram_dq_i)
    );

    // ---------------- behavioural RAM model with its own checks ----------
    logic [DW-1:0] mem [NW];
    int            vcnt, wlow, hold, m_chk, m_fail;
    logic          prev_en, prev_sel, addr_moved, wbad;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] wlatch;

    assign ram_dq_i = (vcnt >= TRD) ? mem[ram_addr_o] : ~mem[ram_addr_o];

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] = '0;
            vcnt = 0; wlow = 0; hold = 0; m_chk = 0; m_fail = 0;
            prev_en = 1'b0; prev_sel = 1'b0; addr_moved = 1'b0; wbad = 1'b0;
            prev_addr = '0; wlatch = '0;
        end else begin
            logic sel, drv;
            sel = !ram_sel_n_o && ram_sel_o;
            drv = sel && !ram_rd_n_o && ram_wr_n_o;
            // read access timing
            if (drv) vcnt = (ram_addr_o == prev_addr && vcnt > 0) ? vcnt + 1 : 1;
            else     vcnt = 0;
            // R8: no drive while the RAM may still be driving
            if (ram_dq_en_o && !prev_en) begin
                m_chk++;
                if (drv || hold > 0) begin
                    m_fail++;
                    $display("FAIL R8 contention: ram_hold=%0d exp=0", hold);
                end
            end
            if (drv) hold = RAM_HOLD; else if (hold > 0) hold--;
            // R7: address steady within a selection
            if (sel && prev_sel && ram_addr_o != prev_addr) addr_moved = 1'b1;
            if (!sel && prev_sel) begin
                m_chk++;
                if (addr_moved) begin
                    m_fail++;
                    $display("FAIL R7 address moved while selected: act=1 exp=0");
                end
                addr_moved = 1'b0;
            end
            // R5/R6: write pulse
            if (!ram_wr_n_o) begin
                wlow++;
                wlatch = ram_dq_o;
                if (!ram_dq_en_o || !ram_rd_n_o || !sel) wbad = 1'b1;
            end else if (wlow > 0) begin
                m_chk++;
                if (wlow != PULSE) begin
                    m_fail++;
                    $display("FAIL R6 write pulse cycles act=%0d exp=%0d", wlow, PULSE);
                end
                m_chk++;
                if (wbad || !ram_dq_en_o) begin
                    m_fail++;
                    $display("FAIL R5 drive/oe during write act=%0d exp=0", wbad);
                end
                mem[ram_addr_o] = wlatch;
                wlow = 0;
                wbad = 1'b0;
            end
            prev_en   = ram_dq_en_o;
            prev_sel  = sel;
            prev_addr = ram_addr_o;
        end
    end

    // ---------------- checks and stimulus ---------------------------------
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        int tot, bad;
        tot = n_chk + m_chk;
        bad = n_fail + m_fail;
        $display("%0d/%0d checks passed", tot - bad, tot);
    endtask

    function automatic logic [DW-1:0] pat_a(input int a);
        return DW'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [DW-1:0] pat_b(input int a);
        return DW'(((a * 91) ^ 8'h5A) & 255);
    endfunction

    task automatic idle_check(input string tag);
        chk(ram_sel_n_o && !ram_sel_o && ram_rd_n_o && ram_wr_n_o && !ram_dq_en_o,
            {tag, " R9 idle strobes"},
            {ram_sel_n_o, ram_sel_o, ram_rd_n_o, ram_wr_n_o, ram_dq_en_o}, 5'b10110);
    endtask

    // one operation; poke raises a request while busy (must be ignored)
    task automatic do_op(input bit wr, input int a, input logic [DW-1:0] d,
                         input int exp_lat, input logic [DW-1:0] exp_rd, input bit poke);
        int lat;
        while (!ready_o) @(negedge clk);
        req_i = 1'b1; wr_i = wr; addr_i = AW'(a); wdata_i = d;
        @(negedge clk);
        req_i = 1'b0;
        lat = 0;
        while (!ready_o && lat < 60) begin
            lat++;
            if (!wr && lat == 2)
                chk(!ram_sel_n_o && ram_sel_o && !ram_rd_n_o && ram_wr_n_o &&
                    !ram_dq_en_o && ram_addr_o == AW'(a), "R3 read strobes",
                    {ram_sel_n_o, ram_sel_o, ram_rd_n_o, ram_wr_n_o, ram_dq_en_o}, 5'b01010);
            if (poke && lat == 2) begin
                req_i = 1'b1; wr_i = 1'b1; addr_i = AW'(NW - 1); wdata_i = 8'hEE;
            end else begin
                req_i = 1'b0;
            end
            @(negedge clk);
        end
        req_i = 1'b0;
        chk(lat == exp_lat, wr ? "R6/R8 write ready-low cycles" : "R3 read ready-low cycles",
            lat, exp_lat);
        idle_check(wr ? "write" : "read");
        if (!wr) begin
            chk(rvalid_o == 1'b1, "R4 rvalid with ready", rvalid_o, 1);
            chk(rdata_o == exp_rd, "R4 read data", rdata_o, exp_rd);
            @(negedge clk);
            chk(rvalid_o == 1'b0, "R4 rvalid one cycle", rvalid_o, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ready_o == 1'b1, "R1 ready in reset", ready_o, 1);
        chk(rvalid_o == 1'b0, "R1 rvalid in reset", rvalid_o, 0);
        idle_check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
        idle_check("R1 after reset");

        // writes after reset / after writes: no turnaround (R6, R8)
        for (int a = 0; a < NW; a++) do_op(1'b1, a, pat_a(a), WR_LAT, '0, 1'b0);
        // reads of every word (R3, R4)
        for (int a = 0; a < NW; a++) do_op(1'b0, a, '0, RD_LAT, pat_a(a), 1'b0);
        // write following a read gets the turnaround (R8), read back
        for (int a = 0; a < NW; a++) begin
            do_op(1'b1, a, pat_b(a), WR_LAT + TTURN, '0, (a == 5));
            if (a == 5) begin
                // R2: the request raised while busy must not have written
                do_op(1'b0, NW - 1, '0, RD_LAT, pat_a(NW - 1), 1'b0);
            end
            do_op(1'b0, a, '0, RD_LAT, pat_b(a), 1'b0);
        end
        // R2: back-to-back writes after a write
        do_op(1'b1, 3, 8'hC3, WR_LAT + TTURN, '0, 1'b0);
        do_op(1'b1, 3, 8'h3C, WR_LAT, '0, 1'b0);
        do_op(1'b0, 3, '0, RD_LAT, 8'h3C, 1'b0);

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish act=0 exp=1");
            report();
            $finish;
        end
    end

endmodule